// File: doc/BRIEF.md
# Program and Data Memory Map Decoder

This block sits beside the core of an 8051-style controller. It decides, for every instruction fetch and every external data move, whether the access is served on chip or has to go out on the external bus. The program side has 16 kB of on-chip store. The data side has 1 kB of on-chip SRAM. The decode logic itself is combinational, so a fetch or data address is classified in the same cycle it is presented.

The on-chip program boundary comes from a 3-bit size code held in this block. Software can move that boundary at run time, but only inside a short write window. The window is opened by an unlock sequence written to a timed-access register. The data map is chosen by a 2-bit mode input:

- All data accesses go external.
- The low 1 kB is on chip and everything else is external.
- One locked mode allows no external access at all and serves a read-only lock-status byte at a fixed address.

The memories, the bus multiplexing and the CPU itself are outside this block.

Top module: `memmap_decoder`

## Requirements
- R1: After reset the size code reads 101 (16 kB). A fetch of 0000h–3FFFh is internal (`prog_int_sel`=1, `pse_n`=1). A fetch of 4000h or above is external (`pse_n`=0).
- R2: The size code sets the on-chip limit as follows: 000 gives 0, 001 gives 1 kB, 010 gives 2 kB, 011 gives 4 kB, 100 gives 8 kB and 101 gives 16 kB. When `fetch_req` is high, an address below the limit selects internal. An address at or above the limit drives `pse_n` low. With `fetch_req` low, `pse_n`=1 and `prog_int_sel`=0.
- R3: With `ext_access_n` low, every requested fetch is external, whatever the size code.
- R4: A size write with value 110 or 111 is dropped, even inside an open window. The previous code is kept.
- R5: A size write (`sfr_wr`=1, `sfr_sel`=1, code in `sfr_wdata[2:0]`) takes effect only while the window is open. The window opens when AAh and then 55h are written to the timed-access register (`sfr_sel`=0). It stays open for 3 `mcycle` ticks after the 55h write; after the third tick it is closed.
- R6: Any timed-access write other than the expected next key abandons the sequence or closes the window. A new AAh restarts the sequence.
- R7: With `dme`=00, every data read or write goes external.
- R8: With `dme`=01, addresses 0000h–03FFh select the internal SRAM and 0400h–FFFFh go external.
- R9: With `dme`=11:
  - 0000h–03FFh are internal.
  - A read of FFFCh raises `stat_valid` with `stat_rdata` = {5'b0, `lock_bits`}.
  - Every other address, and a write to FFFCh, raises `data_blocked`.
- R10: With `dme`=10, every access raises `data_blocked` and there is no external access.
- R11: At most one of internal select, external strobe, blocked and status is active. When `data_blocked` is high, all strobes and the SRAM select stay low. With neither `data_rd` nor `data_wr` high, all data outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mcycle | input | 1 | Machine-cycle tick that times the write window |
| sfr_wr | input | 1 | Register write strobe |
| sfr_sel | input | 1 | 0 = timed-access register, 1 = size register |
| sfr_wdata | input | 8 | Register write data |
| fetch_req | input | 1 | Instruction fetch in progress |
| fetch_addr | input | 16 | Fetch address |
| ext_access_n | input | 1 | Low forces all fetches external |
| data_rd | input | 1 | Data read strobe |
| data_wr | input | 1 | Data write strobe |
| data_addr | input | 16 | Data address |
| dme | input | 2 | Data map mode |
| lock_bits | input | 3 | Lock status bits |
| rom_size_code | output | 3 | Current size code |
| prog_int_sel | output | 1 | Fetch served on chip |
| pse_n | output | 1 | Active-low external program-store enable |
| data_int_sel | output | 1 | On-chip SRAM select |
| data_ext_rd | output | 1 | External data read strobe |
| data_ext_wr | output | 1 | External data write strobe |
| data_blocked | output | 1 | Access reserved or blocked |
| stat_valid | output | 1 | Lock-status byte being read |
| stat_rdata | output | 8 | Lock-status read data |

## Verification
The hardest situation to reach from the ports is the edge of the write window. A size write has to land exactly on the last open tick, or exactly on the first closed one. Interrupted unlock sequences also have to be shown to leave the code untouched. The stimulus counts `mcycle` ticks after the 55h key and writes once after two ticks (accepted) and once after three (ignored). It then reads `rom_size_code` back at the port. Every legal code is then installed through the full unlock path, and the fetch and data address spaces are swept for each code and mode. The sweep includes the addresses on both sides of each boundary.

// File: rtl/memmap_pkg.sv
package memmap_pkg;
  localparam int ROM_CODE_W = 3;
  localparam int ADDR_W     = 16;

  typedef enum logic [1:0] {
    DM_ALL_EXT = 2'b00,
    DM_LOW_INT = 2'b01,
    DM_RSV     = 2'b10,
    DM_LOCKED  = 2'b11
  } dmode_e;

  // Byte limit of on-chip program store for a size code (17 bits so 64 kB fits).
  function automatic logic [ADDR_W:0] rom_limit(input logic [ROM_CODE_W-1:0] code);
    logic [ADDR_W:0] lim;
    lim = '0;
    if (code != 3'd0 && code <= 3'd5)
      lim = (ADDR_W+1)'(1) << (code + 3'd1 + 4'd8);
    return lim;
  endfunction

  function automatic logic rom_code_legal(input logic [ROM_CODE_W-1:0] code);
    return code <= 3'd5;
  endfunction
endpackage

// File: rtl/mm_timed_access.sv
module mm_timed_access #(
  parameter logic [7:0] KEY_A   = 8'hAA,
  parameter logic [7:0] KEY_B   = 8'h55,
  parameter int         WIN_CYC = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ta_wr,
  input  logic [7:0] wdata,
  input  logic       mcycle,
  output logic       win_open
);
  localparam int CNT_W = $clog2(WIN_CYC + 1);

  typedef enum logic [1:0] {TA_IDLE, TA_ARMED, TA_OPEN} ta_state_e;
  ta_state_e        st;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= TA_IDLE;
      cnt <= '0;
    end else if (ta_wr) begin
      if (wdata == KEY_A) begin
        st <= TA_ARMED;
      end else if (wdata == KEY_B && st == TA_ARMED) begin
        st  <= TA_OPEN;
        cnt <= CNT_W'(WIN_CYC);
      end else begin
        st <= TA_IDLE;
      end
    end else if (st == TA_OPEN && mcycle) begin
      if (cnt == CNT_W'(1)) st <= TA_IDLE;
      cnt <= cnt - CNT_W'(1);
    end
  end

  assign win_open = (st == TA_OPEN);
endmodule

// File: rtl/mm_prog_decode.sv
module mm_prog_decode
  import memmap_pkg::*;
(
  input  logic                  fetch_req,
  input  logic [ADDR_W-1:0]     fetch_addr,
  input  logic                  ext_access_n,
  input  logic [ROM_CODE_W-1:0] code,
  output logic                  prog_int_sel,
  output logic                  pse_n
);
  logic go_ext;

  always_comb begin
    go_ext       = !ext_access_n || ({1'b0, fetch_addr} >= rom_limit(code));
    prog_int_sel = fetch_req && !go_ext;
    pse_n        = !(fetch_req && go_ext);
  end
endmodule

// File: rtl/mm_data_decode.sv
module mm_data_decode
  import memmap_pkg::*;
#(
  parameter logic [ADDR_W-1:0] SRAM_LAST = 16'h03FF,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 16'hFFFC
) (
  input  logic              data_rd,
  input  logic              data_wr,
  input  logic [ADDR_W-1:0] data_addr,
  input  logic [1:0]        dme,
  input  logic [2:0]        lock_bits,
  output logic              data_int_sel,
  output logic              data_ext_rd,
  output logic              data_ext_wr,
  output logic              data_blocked,
  output logic              stat_valid,
  output logic [7:0]        stat_rdata
);
  logic acc, low, ext, intl, blk, stat;

  always_comb begin
    acc  = data_rd || data_wr;
    low  = data_addr <= SRAM_LAST;
    ext  = 1'b0;
    intl = 1'b0;
    blk  = 1'b0;
    stat = 1'b0;
    unique case (dmode_e'(dme))
      DM_ALL_EXT: ext = acc;
      DM_LOW_INT: begin
        intl = acc && low;
        ext  = acc && !low;
      end
      DM_RSV: blk = acc;
      DM_LOCKED: begin
        if (low)                                intl = acc;
        else if (data_addr == STAT_ADDR && data_rd && !data_wr) stat = 1'b1;
        else                                    blk  = acc;
      end
      default: blk = acc;
    endcase
    data_int_sel = intl;
    data_ext_rd  = ext && data_rd;
    data_ext_wr  = ext && data_wr && !data_rd;
    data_blocked = blk;
    stat_valid   = stat;
    stat_rdata   = stat ? {5'b0, lock_bits} : 8'h00;
  end
endmodule

// File: rtl/memmap_decoder.sv
module memmap_decoder
  import memmap_pkg::*;
#(
  parameter int                WIN_CYC   = 3,
  parameter logic [ADDR_W-1:0] SRAM_LAST = 16'h03FF,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 16'hFFFC
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mcycle,
  input  logic        sfr_wr,
  input  logic        sfr_sel,
  input  logic [7:0]  sfr_wdata,
  input  logic        fetch_req,
  input  logic [15:0] fetch_addr,
  input  logic        ext_access_n,
  input  logic        data_rd,
  input  logic        data_wr,
  input  logic [15:0] data_addr,
  input  logic [1:0]  dme,
  input  logic [2:0]  lock_bits,
  output logic [2:0]  rom_size_code,
  output logic        prog_int_sel,
  output logic        pse_n,
  output logic        data_int_sel,
  output logic        data_ext_rd,
  output logic        data_ext_wr,
  output logic        data_blocked,
  output logic        stat_valid,
  output logic [7:0]  stat_rdata
);
  localparam logic [ROM_CODE_W-1:0] CODE_RST = 3'd5;

  logic                  win_open;
  logic                  ta_wr;
  logic                  rom_wr_accept;
  logic [ROM_CODE_W-1:0] code_q;

  assign ta_wr         = sfr_wr && !sfr_sel;
  assign rom_wr_accept = sfr_wr && sfr_sel && win_open &&
                         rom_code_legal(sfr_wdata[ROM_CODE_W-1:0]);

  mm_timed_access #(.WIN_CYC(WIN_CYC)) u_ta (
    .clk(clk), .rst_n(rst_n), .ta_wr(ta_wr), .wdata(sfr_wdata),
    .mcycle(mcycle), .win_open(win_open)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             code_q <= CODE_RST;
    else if (rom_wr_accept) code_q <= sfr_wdata[ROM_CODE_W-1:0];
  end
  assign rom_size_code = code_q;

  mm_prog_decode u_prog (
    .fetch_req(fetch_req), .fetch_addr(fetch_addr), .ext_access_n(ext_access_n),
    .code(code_q), .prog_int_sel(prog_int_sel), .pse_n(pse_n)
  );

  mm_data_decode #(.SRAM_LAST(SRAM_LAST), .STAT_ADDR(STAT_ADDR)) u_data (
    .data_rd(data_rd), .data_wr(data_wr), .data_addr(data_addr), .dme(dme),
    .lock_bits(lock_bits), .data_int_sel(data_int_sel), .data_ext_rd(data_ext_rd),
    .data_ext_wr(data_ext_wr), .data_blocked(data_blocked),
    .stat_valid(stat_valid), .stat_rdata(stat_rdata)
  );
endmodule

// File: rtl/memmap_checker.sv
module memmap_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       fetch_req,
  input logic       ext_access_n,
  input logic       pse_n,
  input logic       prog_int_sel,
  input logic       data_rd,
  input logic [1:0] dme,
  input logic       data_int_sel,
  input logic       data_ext_rd,
  input logic       data_ext_wr,
  input logic       data_blocked,
  input logic       stat_valid,
  input logic [7:0] stat_rdata,
  input logic [2:0] lock_bits,
  input logic [2:0] rom_size_code,
  input logic       rom_wr_accept,
  input logic       win_open
);
  AST_EA_OFFCHIP: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req && !ext_access_n |-> !pse_n && !prog_int_sel); // R3
  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    rom_size_code <= 3'd5); // R4
  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rom_wr_accept |=> $stable(rom_size_code)); // R5
  AST_ACCEPT_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    rom_wr_accept |-> win_open); // R5
  AST_MODE_ALLEXT: assert property (@(posedge clk) disable iff (!rst_n)
    dme == 2'b00 && data_rd |-> data_ext_rd); // R7
  AST_MODE_RSV_NOEXT: assert property (@(posedge clk) disable iff (!rst_n)
    dme == 2'b10 |-> !data_ext_rd && !data_ext_wr); // R10
  AST_STATUS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |-> stat_rdata == {5'b0, lock_bits}); // R9
  AST_DATA_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({data_int_sel, data_ext_rd || data_ext_wr, data_blocked, stat_valid})); // R11
endmodule

bind memmap_decoder memmap_checker u_chk (
  .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .ext_access_n(ext_access_n),
  .pse_n(pse_n), .prog_int_sel(prog_int_sel), .data_rd(data_rd), .dme(dme),
  .data_int_sel(data_int_sel), .data_ext_rd(data_ext_rd), .data_ext_wr(data_ext_wr),
  .data_blocked(data_blocked), .stat_valid(stat_valid), .stat_rdata(stat_rdata),
  .lock_bits(lock_bits), .rom_size_code(rom_size_code),
  .rom_wr_accept(rom_wr_accept), .win_open(win_open)
);

// File: tb/test_memmap_decoder.sv
`timescale 1ns/100ps
module test_memmap_decoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mcycle = 1'b0, sfr_wr = 1'b0, sfr_sel = 1'b0;
  logic [7:0] sfr_wdata = 8'h00;
  logic fetch_req = 1'b0, ext_access_n = 1'b1;
  logic [15:0] fetch_addr = 16'h0000, data_addr = 16'h0000;
  logic data_rd = 1'b0, data_wr = 1'b0;
  logic [1:0] dme = 2'b00;
  logic [2:0] lock_bits = 3'b101;
  logic [2:0] rom_size_code;
  logic prog_int_sel, pse_n, data_int_sel, data_ext_rd, data_ext_wr, data_blocked, stat_valid;
  logic [7:0] stat_rdata;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  memmap_decoder i_memmap_decoder (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sfr(input logic sel, input logic [7:0] d);
    @(negedge clk); sfr_wr = 1'b1; sfr_sel = sel; sfr_wdata = d;
    @(negedge clk); sfr_wr = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk); mcycle = 1'b1;
    @(negedge clk); mcycle = 1'b0;
  endtask

  task automatic set_code(input logic [2:0] c);
    sfr(1'b0, 8'hAA); sfr(1'b0, 8'h55); sfr(1'b1, {5'b0, c});
  endtask

  function automatic int lim_of(input int c);
    int t[6] = '{0, 1024, 2048, 4096, 8192, 16384};
    return (c < 6) ? t[c] : 0;
  endfunction

  task automatic fetch_chk(input string req, input int code, input int a, input logic ea_n);
    logic ext;
    fetch_addr = a[15:0]; ext_access_n = ea_n; fetch_req = 1'b1; #0.5;
    ext = !ea_n || (a >= lim_of(code));
    chk(req, {pse_n, prog_int_sel}, {!ext, !ext});
  endtask

  // expected {int, ext_rd, ext_wr, blocked, stat}
  function automatic logic [4:0] dexp(input int m, input int a, input logic rd, input logic wr);
    logic lo;
    lo = a < 1024;
    if (!rd && !wr) return 5'b0;
    case (m)
      0: return {1'b0, rd, wr, 2'b00};
      1: return lo ? 5'b10000 : {1'b0, rd, wr, 2'b00};
      2: return 5'b00010;
      default: return lo ? 5'b10000 : ((a == 16'hFFFC && rd) ? 5'b00001 : 5'b00010);
    endcase
  endfunction

  task automatic data_chk(input int m, input int a, input logic rd, input logic wr);
    string req;
    req = (m == 0) ? "R7" : (m == 1) ? "R8" : (m == 2) ? "R10" : "R9";
    dme = m[1:0]; data_addr = a[15:0]; data_rd = rd; data_wr = wr; #0.5;
    chk(req, {data_int_sel, data_ext_rd, data_ext_wr, data_blocked, stat_valid}, dexp(m, a, rd, wr));
    if (data_blocked) chk("R11", {data_int_sel, data_ext_rd, data_ext_wr}, 3'b000);
    if (stat_valid) chk("R9", stat_rdata, {5'b0, lock_bits});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", rom_size_code, 3'd5);
    fetch_chk("R1", 5, 16'h3FFF, 1'b1);
    fetch_chk("R1", 5, 16'h4000, 1'b1);
    fetch_chk("R1", 5, 16'h0000, 1'b1);
    fetch_req = 1'b0; #0.5;
    chk("R2", {pse_n, prog_int_sel}, 2'b10);

    // R5 window edges
    sfr(1'b1, 8'h03); chk("R5", rom_size_code, 3'd5);
    sfr(1'b0, 8'hAA); sfr(1'b0, 8'h55); tick(); tick(); sfr(1'b1, 8'h03);
    chk("R5", rom_size_code, 3'd3);
    sfr(1'b0, 8'hAA); sfr(1'b0, 8'h55); tick(); tick(); tick(); sfr(1'b1, 8'h02);
    chk("R5", rom_size_code, 3'd3);
    // R6 broken sequences
    sfr(1'b0, 8'hAA); sfr(1'b0, 8'h12); sfr(1'b0, 8'h55); sfr(1'b1, 8'h01);
    chk("R6", rom_size_code, 3'd3);
    sfr(1'b0, 8'hAA); sfr(1'b0, 8'h55); sfr(1'b0, 8'h77); sfr(1'b1, 8'h01);
    chk("R6", rom_size_code, 3'd3);
    sfr(1'b0, 8'h55); sfr(1'b1, 8'h01);
    chk("R6", rom_size_code, 3'd3);
    sfr(1'b0, 8'hAA); sfr(1'b0, 8'hAA); sfr(1'b0, 8'h55); sfr(1'b1, 8'h04);
    chk("R6", rom_size_code, 3'd4);
    // R4 reserved codes
    set_code(3'd6); chk("R4", rom_size_code, 3'd4);
    set_code(3'd7); chk("R4", rom_size_code, 3'd4);

    // R2 / R3 sweeps per code
    for (int c = 0; c < 6; c++) begin
      set_code(c[2:0]);
      chk("R2", rom_size_code, c[2:0]);
      for (int a = 0; a < 65536; a += 61) fetch_chk("R2", c, a, 1'b1);
      if (lim_of(c) > 0) fetch_chk("R2", c, lim_of(c) - 1, 1'b1);
      fetch_chk("R2", c, lim_of(c), 1'b1);
      for (int a = 0; a < 65536; a += 997) fetch_chk("R3", c, a, 1'b0);
      fetch_req = 1'b0;
    end

    // R7..R11 data sweeps
    for (int m = 0; m < 4; m++) begin
      int edges[7] = '{0, 16'h03FF, 16'h0400, 16'hFFFB, 16'hFFFC, 16'hFFFD, 16'hFFFF};
      for (int a = 0; a < 65536; a += 37) begin
        data_chk(m, a, 1'b1, 1'b0);
        data_chk(m, a, 1'b0, 1'b1);
      end
      foreach (edges[i]) begin
        data_chk(m, edges[i], 1'b1, 1'b0);
        data_chk(m, edges[i], 1'b0, 1'b1);
        data_chk(m, edges[i], 1'b0, 1'b0); // R11 idle
      end
    end
    lock_bits = 3'b010; data_chk(3, 16'hFFFC, 1'b1, 1'b0);
    lock_bits = 3'b111; data_chk(3, 16'hFFFC, 1'b1, 1'b0);
    data_rd = 1'b0; data_wr = 1'b0;

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule